// File: doc/BRIEF.md
# Periodic real-time tick generator

This block counts bus cycles and raises a real-time tick flag once every programmed interval. A 2-bit rate field picks an interval of 8192, 16384, 32768 or 65536 cycles (8192 times two to the power of the field). Each interval is measured from the previous scheduled tick and not from when software serviced the flag, so a late service does not move later ticks.

Software reaches three byte-wide registers through a single-cycle write port and a combinational read port. The control register holds the rate field. The flag register holds the tick flag, which is cleared by writing a 1 to it. The mask register holds the enable bit that gates the interrupt request output. A tick sets the flag whether the request is enabled or not.

Top module: `rti_gen`

## Requirements
- R1: The interval between consecutive ticks is 8192 × 2^rate bus cycles. The rate is bits [1:0] of the control register at address 0: 00 gives 8192, 01 gives 16384, 10 gives 32768 and 11 gives 65536 cycles.
- R2: On each tick, bit 6 of the flag register (address 1) is set in the same clock edge.
- R3: A write to address 1 with data bit 6 = 1 clears the flag. A write with data bit 6 = 0 leaves the flag unchanged. If a tick and a clearing write fall on the same edge, the tick wins and the flag stays set.
- R4: A tick is scheduled one interval after the previous tick, whenever the flag was cleared or read.
- R5: A write to the rate field sets no flag on that write. Timing continues from the previous tick with the new interval. If the new interval has already elapsed, the tick comes on the next edge.
- R6: An asynchronous reset (rst_ni low) returns the rate to 00, the flag and enable to 0, and the tick reference to zero. The first tick then comes on the 8192nd rising edge after reset is released.
- R7: irq_o is high exactly when the flag is set and enable bit 6 of the mask register (address 2) is set.
- R8: The read port returns the register selected by rd_addr_i, with unused bits at 0. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address (0 control, 1 flag, 2 mask) |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data of the selected register |
| irq_o | output | 1 | Real-time interrupt request |

## Verification
A wrong cycle count or a badly decoded rate shows as a flag rise one or more cycles away from the expected edge. A per-cycle model exposes such an error on the first tick after it. A tick reference that restarts when the flag is cleared, or when the rate is written, shifts the next rise by the service delay, so the measured interval between rises is wrong by a whole number of cycles. Errors in the clear logic or the enable gating show on the read data or on irq_o in the cycle after the write.

// File: rtl/rti_pkg.sv
package rti_pkg;
  localparam int ADDR_W   = 2;
  localparam int DATA_W   = 8;
  localparam int RATE_W   = 2;
  localparam int FLAG_BIT = 6;
  localparam int EN_BIT   = 6;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_FLAG = 2'd1,
    ADDR_MASK = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/rti_sched.sv
module rti_sched
  import rti_pkg::*;
#(
  parameter int BASE_LOG2 = 13,
  localparam int CNT_W = BASE_LOG2 + (1 << RATE_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   period;
  logic [CNT_W:0]   last_cnt;

  always_comb begin
    period   = (CNT_W+1)'(1) << (BASE_LOG2 + int'(rate_i));
    last_cnt = period - (CNT_W+1)'(1);
  end

  // >= covers a rate change to an interval already passed
  assign tick_o = ({1'b0, cnt_q} >= last_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R4
  tick_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  // R1
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> (cnt_q != '0));
endmodule

// File: rtl/rti_regs.sv
module rti_regs
  import rti_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              tick_i,
  output logic [RATE_W-1:0] rate_o,
  output logic              flag_o,
  output logic              en_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [RATE_W-1:0] rate_q;
  logic flag_q, en_q;
  logic wr_ctrl, wr_flag, wr_mask, clr_req;

  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_flag = wr_en_i && (wr_addr_i == ADDR_FLAG);
  assign wr_mask = wr_en_i && (wr_addr_i == ADDR_MASK);
  assign clr_req = wr_flag && wr_data_i[FLAG_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= '0;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_ctrl) rate_q <= wr_data_i[RATE_W-1:0];
      if (wr_mask) en_q   <= wr_data_i[EN_BIT];
      // tick has priority over a clearing write
      if (tick_i)       flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      ADDR_CTRL: rd_data_o[RATE_W-1:0] = rate_q;
      ADDR_FLAG: rd_data_o[FLAG_BIT]   = flag_q;
      ADDR_MASK: rd_data_o[EN_BIT]     = en_q;
      default:   rd_data_o = '0;
    endcase
  end

  assign rate_o = rate_q;
  assign flag_o = flag_q;
  assign en_o   = en_q;

  // R2
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> flag_q);
  // R3
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_req && !tick_i) |=> !flag_q);
  // R3
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_req) |=> $stable(flag_q));
  // R5
  flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(tick_i));
endmodule

// File: rtl/rti_gen.sv
module rti_gen
  import rti_pkg::*;
#(
  parameter int BASE_LOG2 = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic              tick;
  logic [RATE_W-1:0] rate;
  logic              flag, en;

  rti_sched #(.BASE_LOG2(BASE_LOG2)) u_sched (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rate_i (rate),
    .tick_o (tick)
  );

  rti_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .tick_i    (tick),
    .rate_o    (rate),
    .flag_o    (flag),
    .en_o      (en),
    .rd_data_o (rd_data_o)
  );

  assign irq_o = flag && en;

  // R7
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && en) |=> irq_o);
endmodule

// File: tb/rti_gen_tb.sv
module rti_gen_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = 2'd0;
  logic [7:0] wr_data_i = 8'd0;
  logic [1:0] rd_addr_i = 2'd1;
  logic [7:0] rd_data_o;
  logic       irq_o;

  int tests = 0, fails = 0, shown = 0;
  int cyc = 0;
  int last_rise = 0, prev_rise = 0;
  logic prev_flag = 1'b0;
  bit done = 0;

  // reference model state
  int  m_elapsed = 0;
  int  m_rate = 0;
  bit  m_flag = 0, m_en = 0;

  always #5 clk_i = ~clk_i;

  rti_gen u_dut (.*);

  function automatic int period_of(int r);
    return 8192 << r;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_elapsed = 0; m_rate = 0; m_flag = 0; m_en = 0; cyc = 0;
    end else begin
      bit t;
      cyc++;
      t = (m_elapsed + 1 >= period_of(m_rate));
      m_elapsed = t ? 0 : m_elapsed + 1;
      if (t) m_flag = 1;
      else if (wr_en_i && wr_addr_i == 2'd1 && wr_data_i[6]) m_flag = 0;
      if (wr_en_i && wr_addr_i == 2'd0) m_rate = int'(wr_data_i[1:0]);
      if (wr_en_i && wr_addr_i == 2'd2) m_en = wr_data_i[6];
    end
  end

  function automatic logic [7:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0: return {6'd0, 2'(m_rate)};
      2'd1: return {1'b0, m_flag, 6'd0};
      2'd2: return {1'b0, m_en, 6'd0};
      default: return 8'd0;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      if (shown < 40) begin
        shown++;
        $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check("R8 rd_data", int'(rd_data_o), int'(exp_rd(rd_addr_i)));
      check("R7 irq", int'(irq_o), int'(m_flag && m_en));
      if (rd_addr_i == 2'd1) begin
        if (rd_data_o[6] && !prev_flag) begin
          prev_rise = last_rise;
          last_rise = cyc;
        end
        prev_flag = rd_data_o[6];
      end
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_rise();
    int start;
    start = last_rise;
    while (last_rise == start) @(negedge clk_i);
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R6 reset state, R8 read map
    rd_addr_i = 2'd0; #1; check("R6 reset rate", int'(rd_data_o), 0);
    rd_addr_i = 2'd1; #1; check("R6 reset flag", int'(rd_data_o), 0);
    rd_addr_i = 2'd2; #1; check("R6 reset en", int'(rd_data_o), 0);
    check("R7 reset irq", int'(irq_o), 0);
    rd_addr_i = 2'd1;
    rst_ni = 1'b1;
    wr(2'd2, 8'h40);
    wait_rise();
    check("R6 first tick edge", last_rise, 8192);
    check("R7 irq with en", int'(irq_o), 1);
    repeat (100) @(negedge clk_i);
    wr(2'd1, 8'h00);
    check("R3 write 0 keeps flag", int'(rd_data_o[6]), 1);
    wr(2'd1, 8'hBF);
    check("R3 other bits keep flag", int'(rd_data_o[6]), 1);
    wr(2'd1, 8'h40);
    check("R3 write 1 clears", int'(rd_data_o[6]), 0);
    check("R7 irq low after clear", int'(irq_o), 0);
    wait_rise();
    check("R4 no slip after late clear", last_rise - prev_rise, 8192);
    wr(2'd2, 8'h00);
    check("R7 masked irq", int'(irq_o), 0);
    check("R2 flag set while masked", int'(rd_data_o[6]), 1);
    wr(2'd1, 8'h40);
    wr(2'd2, 8'h40);
    repeat (1000) @(negedge clk_i);
    wr(2'd0, 8'h01);
    check("R5 no flag on rate write", int'(rd_data_o[6]), 0);
    rd_addr_i = 2'd0; #1; check("R8 rate readback", int'(rd_data_o), 1);
    rd_addr_i = 2'd3; #1; check("R8 unused addr", int'(rd_data_o), 0);
    rd_addr_i = 2'd1;
    wait_rise();
    check("R5 interval from previous tick", last_rise - prev_rise, 16384);
    wr(2'd1, 8'h40);
    wr(2'd0, 8'h02);
    wait_rise();
    check("R1 rate 10 interval", last_rise - prev_rise, 32768);
    wr(2'd1, 8'h40);
    wr(2'd0, 8'h03);
    wait_rise();
    check("R1 rate 11 interval", last_rise - prev_rise, 65536);
    // rate back to 00 well past 8192 cycles: tick on next edge
    repeat (9000) @(negedge clk_i);
    wr(2'd1, 8'h40);
    wr(2'd0, 8'h00);
    @(negedge clk_i);
    check("R5 overdue tick next edge", int'(rd_data_o[6]), 1);
    // clear colliding with a tick: tick wins (R3)
    wait_rise();
    wr(2'd1, 8'h40);
    repeat (8192 - 4) @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 2'd1; wr_data_i = 8'h40;
    while (!(u_dut.rd_data_o[6])) @(negedge clk_i);
    wr_en_i = 1'b0;
    @(negedge clk_i);
    check("R3 tick beats clear", int'(rd_data_o[6]), 1);
    // R6 reset mid-run clears reference
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    prev_flag = 1'b0; last_rise = 0;
    rst_ni = 1'b1;
    wait_rise();
    check("R6 tick after re-reset", last_rise, 8192);
    finish_run();
  end
endmodule